// File: doc/BRIEF.md
# Alternating-Threshold Hysteresis Input Sampler

This block controls a bank of isolated digital inputs that share one reference level, produced by an external DAC. In hysteresis mode it alternates the DAC between a programmed low code and a programmed high code, one phase per switch. It waits a settle time after each switch, takes one snapshot of every input, and resolves each channel from the last low/high pair. A channel that reads 1 against both references becomes 1, and one that reads 0 against both becomes 0. A channel whose two readings disagree keeps its previous value, so a signal lying between the thresholds does not chatter.

With hysteresis off, the block drives the smaller of the two programmed codes as a single fixed reference. Every snapshot then goes straight to the output. Software programs the mode bit and the two codes through a small write port, and may do so at any time. A new setting is picked up only at the start of a low phase, so the two halves of a pair always use matching codes. The resolved bits sit in the low part of a 32-bit result word with a one-cycle valid pulse per result. The default phase length gives a 2 kHz switching rate from a 50 MHz clock.

Top module: `hyst_sampler`

## Requirements
- R1: A phase starts every PHASE_CYC clock cycles. The first phase starts on the first clock edge after reset is released. Each phase start shows as a one-cycle `dac_load` pulse together with the new `dac_code`.
- R2: The input snapshot is taken on the clock edge SETTLE_CYC cycles after the edge that raised `dac_load`. Values on `raw_in` at other times in the phase have no effect on the result.
- R3: Writing address 0 sets the hysteresis enable from data bit 18. Address 1 writes the low code and address 2 writes the high code, each from data bits 9..0. Writes to address 3 are ignored. After reset the enable is 0, the low code is 0x100 and the high code is 0x300.
- R4: In hysteresis mode, each channel's result is 0 when both samples of the pair are 0 and 1 when both are 1. When the two samples differ, the channel keeps its previous result.
- R5: With hysteresis off, each phase drives the smaller programmed code, and that phase's snapshot becomes the result directly.
- R6: `res_word` carries the resolved channels in bits 23..0, and bits 31..24 always read 0. From reset until the first result, `res_word` is 0. Between results it does not change.
- R7: Code and mode writes take effect only at the start of the next low phase. With hysteresis off, every phase start is such a point. A write made between the low and high phases of a pair does not change that pair's high code.
- R8: If the programmed low code is greater than the high code, the two are swapped internally. The low phase always drives the smaller code.
- R9: `res_valid` pulses once per completed pair in hysteresis mode, in the cycle after the high-phase sample. With hysteresis off, it pulses once per phase.
- R10: In hysteresis mode, `dac_code` alternates between low and high, starting with low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 mode, 1 low code, 2 high code, 3 unused) |
| cfg_wdata | input | 32 | Register write data |
| dac_code | output | 10 | Reference code for the external DAC |
| dac_load | output | 1 | One-cycle pulse when `dac_code` takes a new phase value |
| raw_in | input | 24 | Raw input comparator bits against the current reference |
| res_word | output | 32 | Resolved channels in bits 23..0, upper bits zero |
| res_valid | output | 1 | One-cycle pulse when `res_word` holds a new result |

## Verification
The assertions check these on every cycle:
- `dac_code` moves only with `dac_load`, and load pulses never come back to back.
- In hysteresis mode, the high-phase code is never below the committed low code.
- In hysteresis mode, a result pulse falls only in a high phase.
- The result word stays still between pulses.
- A channel whose two samples agree takes the sampled value.

Only the bench's scenarios can show the rest: that a channel holds its state through a disagreeing pair, that junk on the inputs before the settle point is ignored, that a code write landing mid-pair is deferred to the next low phase, and that reversed codes are swapped.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

  // register select on the write port
  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // bit in the mode word that turns hysteresis on
  localparam int unsigned MODE_HYST_BIT = 18;

endpackage

// File: rtl/hyst_phase_timer.sv
module hyst_phase_timer #(
  parameter int unsigned PHASE_CYC  = 25000,
  parameter int unsigned SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_start,
  output logic smp_evt
);
  localparam int unsigned CW = (PHASE_CYC > 2) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT   = CW'(PHASE_CYC - 1);
  localparam logic [CW-1:0] SETTLE_CNT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign ph_start = (cnt_q == '0);
  assign smp_evt  = (cnt_q == SETTLE_CNT);

  // R1: phase starts are at least two cycles apart
  assert_phase_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ph_start |=> !ph_start);

endmodule

// File: rtl/hyst_cfg_regs.sv
module hyst_cfg_regs
  import hyst_pkg::*;
#(
  parameter int unsigned DW     = 10,
  parameter int unsigned LO_RST = 'h100,
  parameter int unsigned HI_RST = 'h300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  output logic          en_pend,
  output logic [DW-1:0] lo_ord,
  output logic [DW-1:0] hi_ord
);
  logic [DW-1:0] lo_q, hi_q;

  function automatic logic [DW-1:0] min_code(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic [DW-1:0] max_code(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_pend <= 1'b0;
      lo_q    <= DW'(LO_RST);
      hi_q    <= DW'(HI_RST);
    end else if (we) begin
      case (reg_sel_e'(addr))
        REG_MODE: en_pend <= wdata[MODE_HYST_BIT];
        REG_LO:   lo_q    <= wdata[DW-1:0];
        REG_HI:   hi_q    <= wdata[DW-1:0];
        default:  ;
      endcase
    end
  end

  assign lo_ord = min_code(lo_q, hi_q);
  assign hi_ord = max_code(lo_q, hi_q);

  wire unused_wdata_bits = ^{wdata[31:MODE_HYST_BIT+1], wdata[MODE_HYST_BIT-1:DW]};

endmodule

// File: rtl/hyst_resolver.sv
module hyst_resolver #(
  parameter int unsigned CH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_evt,
  input  logic          bypass,
  input  logic          phase_hi,
  input  logic [CH-1:0] raw,
  output logic [CH-1:0] res_bits,
  output logic          res_valid
);
  logic [CH-1:0] lo_smp_q;

  // agreeing samples win; disagreement keeps the old state
  function automatic logic [CH-1:0] resolve_pair(input logic [CH-1:0] lo_s,
                                                 input logic [CH-1:0] hi_s,
                                                 input logic [CH-1:0] prev);
    return (lo_s & hi_s) | (prev & (lo_s | hi_s));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_smp_q  <= '0;
      res_bits  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (smp_evt) begin
        if (bypass) begin
          res_bits  <= raw;
          res_valid <= 1'b1;
        end else if (!phase_hi) begin
          lo_smp_q <= raw;
        end else begin
          res_bits  <= resolve_pair(lo_smp_q, raw, res_bits);
          res_valid <= 1'b1;
        end
      end
    end
  end

  // R6: result is frozen between result pulses
  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_bits));

  // R4: an agreeing pair lands as the sampled value
  assert_agree_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_evt && !bypass && phase_hi && (lo_smp_q == raw)) |=> (res_bits == $past(raw)));

endmodule

// File: rtl/hyst_sampler.sv
module hyst_sampler #(
  parameter int unsigned CH         = 24,
  parameter int unsigned DW         = 10,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PHASE_CYC  = 25000,
  parameter int unsigned SETTLE_CYC = 500,
  parameter int unsigned LO_RST     = 'h100,
  parameter int unsigned HI_RST     = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [DW-1:0]     dac_code,
  output logic              dac_load,
  input  logic [CH-1:0]     raw_in,
  output logic [WORD_W-1:0] res_word,
  output logic              res_valid
);
  localparam int unsigned PAD_W = WORD_W - CH;

  logic          ph_start, smp_evt, commit;
  logic          en_pend, hyst_act, phase_hi;
  logic [DW-1:0] lo_ord, hi_ord, lo_act, hi_act;
  logic [CH-1:0] res_bits;

  hyst_phase_timer #(.PHASE_CYC(PHASE_CYC), .SETTLE_CYC(SETTLE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .ph_start(ph_start), .smp_evt(smp_evt));

  hyst_cfg_regs #(.DW(DW), .LO_RST(LO_RST), .HI_RST(HI_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_pend(en_pend), .lo_ord(lo_ord), .hi_ord(hi_ord));

  // a pair boundary: start of a low phase, or any phase in single-reference mode
  assign commit = ph_start && (phase_hi || !hyst_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hyst_act <= 1'b0;
      phase_hi <= 1'b1;
      lo_act   <= DW'(LO_RST);
      hi_act   <= DW'(HI_RST);
      dac_code <= '0;
      dac_load <= 1'b0;
    end else begin
      dac_load <= ph_start;
      if (commit) begin
        hyst_act <= en_pend;
        lo_act   <= lo_ord;
        hi_act   <= hi_ord;
        phase_hi <= 1'b0;
        dac_code <= lo_ord;
      end else if (ph_start) begin
        phase_hi <= 1'b1;
        dac_code <= hi_act;
      end
    end
  end

  hyst_resolver #(.CH(CH)) res_i (
    .clk(clk), .rst_n(rst_n), .smp_evt(smp_evt), .bypass(!hyst_act),
    .phase_hi(phase_hi), .raw(raw_in), .res_bits(res_bits), .res_valid(res_valid));

  assign res_word = {{PAD_W{1'b0}}, res_bits};

  // R10: the reference moves only together with its load pulse
  assert_dac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load |-> $stable(dac_code));

  // R8: the high phase never drives below the committed low code
  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_load && hyst_act && phase_hi) |-> (dac_code >= lo_act));

  // R9: in hysteresis mode a result appears only after the high-phase sample
  assert_pair_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && hyst_act) |-> phase_hi);

  // R9: result pulses are single cycles
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: tb/hyst_sampler_tb.sv
`timescale 1ns/1ps
module hyst_sampler_tb_top;
  localparam int CH = 24;
  localparam int DW = 10;
  localparam int PH = 20;
  localparam int ST = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [DW-1:0] dac_code;
  logic          dac_load;
  logic [CH-1:0] raw_in = '0;
  logic [31:0]   res_word;
  logic          res_valid;

  always #10 clk = ~clk;

  hyst_sampler #(.CH(CH), .DW(DW), .WORD_W(32), .PHASE_CYC(PH), .SETTLE_CYC(ST),
                 .LO_RST('h100), .HI_RST('h300)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dac_code(dac_code), .dac_load(dac_load), .raw_in(raw_in),
    .res_word(res_word), .res_valid(res_valid));

  int n_chk = 0, n_fail = 0, cyc = 0, last_load = -1;
  bit done = 1'b0;
  always @(posedge clk) cyc++;

  // bench model
  bit            p_en = 0, m_en = 0, m_hi_ph = 1;
  logic [DW-1:0] p_lo = 'h100, p_hi = 'h300, m_lo = 'h100, m_hc = 'h300;
  logic [CH-1:0] m_out = '0, m_lsmp = '0;

  function automatic logic [CH-1:0] pair_model(input logic [CH-1:0] a, input logic [CH-1:0] b,
                                                input logic [CH-1:0] prev);
    logic [CH-1:0] r;
    for (int i = 0; i < CH; i++) r[i] = (a[i] == b[i]) ? a[i] : prev[i];
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: p_en = d[18];
      2'd1: p_lo = d[DW-1:0];
      2'd2: p_hi = d[DW-1:0];
      default: ;
    endcase
  endtask

  task automatic run_phase(input logic [CH-1:0] val, input string ctag, input string rtag);
    logic [DW-1:0] exp_code;
    bit exp_v;
    int k = 0;
    while (!dac_load && k < 2 * PH) begin @(negedge clk); k++; end
    check("R1", "load pulse seen", {31'd0, dac_load}, 32'd1);
    if (last_load >= 0) check("R1", "phase spacing", 32'(cyc - last_load), 32'(PH));
    last_load = cyc;
    if (m_hi_ph || !m_en) begin
      m_en = p_en;
      m_lo = (p_lo > p_hi) ? p_hi : p_lo;
      m_hc = (p_lo > p_hi) ? p_lo : p_hi;
      m_hi_ph = 0;
      exp_code = m_lo;
    end else begin
      m_hi_ph = 1;
      exp_code = m_hc;
    end
    check(ctag, "dac_code", 32'(dac_code), 32'(exp_code));
    if (!m_en) begin m_out = val; exp_v = 1; end
    else if (!m_hi_ph) begin m_lsmp = val; exp_v = 0; end
    else begin m_out = pair_model(m_lsmp, val, m_out); exp_v = 1; end
    raw_in = ~val;                         // junk before the settle point (R2)
    repeat (ST - 1) @(negedge clk);
    raw_in = val;
    @(negedge clk);
    check("R9", "res_valid", {31'd0, res_valid}, {31'd0, exp_v});
    check(rtag, "res_word", res_word, {8'd0, m_out});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<%0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R6", "reset res_word", res_word, 32'd0);
    check("R9", "reset res_valid", {31'd0, res_valid}, 32'd0);
    check("R1", "reset dac_load", {31'd0, dac_load}, 32'd0);
    rst_n = 1'b1;
    check("R6", "res_word before first result", res_word, 32'd0);

    // single-reference mode with default codes (R3 defaults, R5)
    run_phase(24'hA5A5A5, "R3", "R5");
    run_phase(24'h0F0F0F, "R5", "R5");
    run_phase(24'hFFFFFF, "R5", "R2");

    // enable hysteresis, takes effect at next phase start (R7)
    cfg_write(2'd0, 32'h0004_0000);
    run_phase(24'hFF00F0, "R10", "R4");   // low sample
    run_phase(24'hF0F00F, "R10", "R4");   // high: agree -> set/clear, differ -> hold
    run_phase(24'h000000, "R10", "R4");
    run_phase(24'h000000, "R10", "R4");   // both 0 -> all clear
    run_phase(24'h123456, "R10", "R4");
    run_phase(24'hFFFFFF, "R10", "R4");   // all differ except ones -> hold zeros
    check("R6", "upper bits zero", {24'd0, res_word[31:24]}, 32'd0);

    // mid-pair write: after a low phase, change codes (R7)
    run_phase(24'h00FFFF, "R10", "R4");   // low
    cfg_write(2'd1, 32'h0000_0040);
    cfg_write(2'd2, 32'h0000_03C0);
    run_phase(24'h0F0F0F, "R7", "R4");    // still old high code
    run_phase(24'h333333, "R7", "R4");    // new low code
    run_phase(24'h333333, "R7", "R4");

    // reversed codes are swapped (R8)
    cfg_write(2'd1, 32'hFFFF_F3A0);
    cfg_write(2'd2, 32'h0000_0050);
    run_phase(24'h555555, "R8", "R4");
    run_phase(24'hAAAAAA, "R8", "R4");
    run_phase(24'hFFFFFF, "R8", "R4");
    run_phase(24'h000000, "R8", "R4");

    // address 3 is ignored (R3)
    cfg_write(2'd3, 32'hFFFF_FFFF);
    run_phase(24'h00FF00, "R3", "R3");
    run_phase(24'h00FF00, "R3", "R3");

    // random stimulus with random rewrites
    for (int i = 0; i < 240; i++) begin
      logic [CH-1:0] v;
      v = CH'($urandom);
      run_phase(v, "R10", "R4");
      if ($urandom % 6 == 0) cfg_write(2'($urandom % 4), $urandom);
      if ($urandom % 25 == 0) cfg_write(2'd0, {13'd0, 1'($urandom), 18'd0});
    end

    // back to single reference (R5)
    cfg_write(2'd0, 32'h0);
    run_phase(24'hDEADBE, "R5", "R5");
    run_phase(24'hDEADBE, "R5", "R5");
    run_phase(24'h135790, "R5", "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule